// File: doc/BRIEF.md
# PCI Target Window Decode and Address Rebase

This block sits behind the target side of a PCI interface. When the bus presents a transaction address, the block decides whether the address falls inside one of the device's two base-address windows. One window is for memory and one is for I/O, and a type flag picks which of the two is looked at. On a hit, the block asserts a one-cycle claim, which is the signal that drives device select. It also produces the local address the access should reach. That local address is the address's offset within the window, added to a programmable local base pointer kept for that space.

Each window is described by a base-address value and a mask. A set mask bit means the address bit must equal the corresponding base bit. Clear mask bits form the offset. A window can be shut in two ways: by its enable bit in the low two bits of the PCI command register, or by a mask of zero. Bus phases, data movement and the local memory port lie outside the block.

Top module: `pci_bar_xlate`

## Requirements
- R1: A memory request (`req_is_io`=0) is claimed only if `space_en[1]` is 1. An I/O request (`req_is_io`=1) is claimed only if `space_en[0]` is 1.
- R2: A window whose mask is zero never claims, even with its enable bit set.
- R3: A request hits when `(req_addr ^ bar) & mask` is zero. For example, base 0xE0000000 with mask 0xFFFC0000 claims 0xE0000000 through 0xE003FFFF and does not claim 0xE0040000.
- R4: On a memory hit, `local_addr` = `mem_base` + (`req_addr` & ~`mem_mask`), modulo 2^32. With base 0, address 0xE0001234 gives 0x00001234.
- R5: On an I/O hit, `local_addr` = `io_base` + (`req_addr` & ~`io_mask`). For example, base 0xFFC04000, window 0xFFFE0000/0xFFFF0000, address 0xFFFE0010 gives 0xFFC04010.
- R6: `claim` and `local_addr` are registered. They reflect the request presented with `req_vld`=1 one clock earlier, and `claim` is high for exactly that one cycle per hit.
- R7: Only the space selected by `req_is_io` is decoded. An address that would hit the other window does not claim. A miss, or a cycle with `req_vld`=0, leaves `claim` low and `local_addr` unchanged.
- R8: With masks 0xF8000000 (memory) and 0xFFFF0000 (I/O), the windows span 128 MB and 64 KB, so the last claimed addresses are base+0x07FFFFFF and base+0xFFFF.
- R9: After reset, `claim` is 0 and `local_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A target address is presented this cycle |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| space_en | input | 2 | Command register bits: [1] memory enable, [0] I/O enable |
| mem_bar | input | 32 | Memory window base address |
| mem_mask | input | 32 | Memory window mask |
| io_bar | input | 32 | I/O window base address |
| io_mask | input | 32 | I/O window mask |
| mem_base | input | 32 | Local base for memory hits |
| io_base | input | 32 | Local base for I/O hits |
| claim | output | 1 | One-cycle claim of the previous request |
| local_addr | output | 32 | Translated local address of the last hit |

## Verification
The assertions relate each claim and translated address to the inputs sampled at the previous edge. They therefore assume that the window settings, bases and enables seen at that edge are the ones the request was decoded against. They also assume that no input is unknown once reset is released. The stimulus changes settings only on a falling edge, in a cycle where it presents no request, so every request is decoded against settings that are already stable. Requests are likewise applied on falling edges and stay constant through the next rising edge.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
    localparam int ADDR_W   = 32;
    localparam int N_SPACES = 2;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/bar_window.sv
module bar_window #(
    parameter int AW = 32
) (
    input  logic          win_en,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] bar,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] lbase,
    output logic          hit,
    output logic [AW-1:0] xlat
);
    logic          mask_live;
    logic          bits_equal;
    logic [AW-1:0] offset;

    always_comb begin
        mask_live  = |mask;
        bits_equal = ((addr ^ bar) & mask) == '0;
        hit        = win_en && mask_live && bits_equal;
        offset     = addr & ~mask;
        xlat       = lbase + offset;
    end
endmodule

// File: rtl/pci_bar_xlate.sv
module pci_bar_xlate
    import pci_bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic [1:0]        space_en,
    input  logic [ADDR_W-1:0] mem_bar,
    input  logic [ADDR_W-1:0] mem_mask,
    input  logic [ADDR_W-1:0] io_bar,
    input  logic [ADDR_W-1:0] io_mask,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] io_base,
    output logic              claim,
    output logic [ADDR_W-1:0] local_addr
);
    localparam int EN_IO_BIT  = 0;
    localparam int EN_MEM_BIT = 1;

    addr_t win_bar  [N_SPACES];
    addr_t win_mask [N_SPACES];
    addr_t win_base [N_SPACES];
    logic  win_en   [N_SPACES];
    logic  win_hit  [N_SPACES];
    addr_t win_xlat [N_SPACES];

    always_comb begin
        win_bar[SPACE_MEM]  = mem_bar;
        win_mask[SPACE_MEM] = mem_mask;
        win_base[SPACE_MEM] = mem_base;
        win_en[SPACE_MEM]   = space_en[EN_MEM_BIT];
        win_bar[SPACE_IO]   = io_bar;
        win_mask[SPACE_IO]  = io_mask;
        win_base[SPACE_IO]  = io_base;
        win_en[SPACE_IO]    = space_en[EN_IO_BIT];
    end

    for (genvar s = 0; s < N_SPACES; s++) begin : g_win
        bar_window #(.AW(ADDR_W)) u_win (
            .win_en (win_en[s]),
            .addr   (req_addr),
            .bar    (win_bar[s]),
            .mask   (win_mask[s]),
            .lbase  (win_base[s]),
            .hit    (win_hit[s]),
            .xlat   (win_xlat[s])
        );
    end

    space_e sel;
    logic   take;
    addr_t  xlat_sel;

    always_comb begin
        sel      = space_e'(req_is_io);
        take     = req_vld && win_hit[sel];
        xlat_sel = win_xlat[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim      <= 1'b0;
            local_addr <= '0;
        end else begin
            claim <= take;
            if (take) begin
                local_addr <= xlat_sel;
            end
        end
    end
endmodule

// File: rtl/pci_bar_xlate_chk.sv
module pci_bar_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [31:0] req_addr,
    input logic        req_is_io,
    input logic [1:0]  space_en,
    input logic [31:0] mem_bar,
    input logic [31:0] mem_mask,
    input logic [31:0] io_bar,
    input logic [31:0] io_mask,
    input logic [31:0] mem_base,
    input logic [31:0] io_base,
    input logic        claim,
    input logic [31:0] local_addr
);
    // R1
    mem_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !$past(req_is_io)) |-> $past(space_en[1]));

    // R1
    io_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && $past(req_is_io)) |-> $past(space_en[0]));

    // R2
    mem_mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !$past(req_is_io)) |-> ($past(mem_mask) != 32'h0));

    // R2
    io_mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && $past(req_is_io)) |-> ($past(io_mask) != 32'h0));

    // R3
    mem_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !$past(req_is_io)) |->
        ((($past(req_addr) ^ $past(mem_bar)) & $past(mem_mask)) == 32'h0));

    // R3
    io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && $past(req_is_io)) |->
        ((($past(req_addr) ^ $past(io_bar)) & $past(io_mask)) == 32'h0));

    // R4
    mem_rebase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !$past(req_is_io)) |->
        (local_addr == $past(mem_base) + ($past(req_addr) & ~$past(mem_mask))));

    // R5
    io_rebase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && $past(req_is_io)) |->
        (local_addr == $past(io_base) + ($past(req_addr) & ~$past(io_mask))));

    // R6
    claim_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> $past(req_vld));

    // R7
    miss_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> $stable(local_addr));
endmodule

bind pci_bar_xlate pci_bar_xlate_chk u_chk (.*);

// File: tb/sim_pci_bar_xlate.sv
module sim_pci_bar_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic [1:0]  space_en = '0;
    logic [31:0] mem_bar = '0, mem_mask = '0, io_bar = '0, io_mask = '0;
    logic [31:0] mem_base = '0, io_base = '0;
    logic        claim;
    logic [31:0] local_addr;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic        c;
        logic [31:0] a;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] model_addr = '0;

    always #4 clk = ~clk;

    pci_bar_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_is_io(req_is_io), .space_en(space_en), .mem_bar(mem_bar),
        .mem_mask(mem_mask), .io_bar(io_bar), .io_mask(io_mask),
        .mem_base(mem_base), .io_base(io_base), .claim(claim),
        .local_addr(local_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies a request on a falling edge and queues the outcome the
    // requirements predict for the next rising edge.
    task automatic drive(input logic v, input logic [31:0] a, input logic io, input string tag);
        logic        en, hit;
        logic [31:0] m, b, base;
        @(negedge clk);
        req_vld = v; req_addr = a; req_is_io = io;
        en   = io ? space_en[0] : space_en[1];
        m    = io ? io_mask : mem_mask;
        b    = io ? io_bar : mem_bar;
        base = io ? io_base : mem_base;
        hit  = v && en && (m != 0) && (((a ^ b) & m) == 0);
        if (hit) model_addr = base + (a & ~m);
        sb.push_back('{c: hit, a: model_addr, tag: tag});
    endtask

    task automatic setcfg(input logic [1:0] en, input logic [31:0] mb, input logic [31:0] mm,
                          input logic [31:0] ib, input logic [31:0] im,
                          input logic [31:0] mbase, input logic [31:0] ibase);
        @(negedge clk);
        req_vld = 1'b0;
        space_en = en; mem_bar = mb; mem_mask = mm; io_bar = ib; io_mask = im;
        mem_base = mbase; io_base = ibase;
        sb.push_back('{c: 1'b0, a: model_addr, tag: "R7 idle"});
    endtask

    // Monitor: compares each rising edge's result with the queued item.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " claim"}, {31'b0, claim}, {31'b0, it.c});
            check({it.tag, " addr"}, local_addr, it.a);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset claim", {31'b0, claim}, 32'h0);
        check("R9 reset addr", local_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        setcfg(2'b11, 32'hE000_0000, 32'hFFFC_0000, 32'hFFFE_0000, 32'hFFFF_0000,
               32'h0, 32'hFFC0_4000);
        drive(1, 32'hE000_1234, 0, "R4 mem rebase");
        drive(1, 32'hE003_FFFF, 0, "R3 top of window");
        drive(1, 32'hE004_0000, 0, "R3 past window");
        drive(1, 32'hE000_0000, 0, "R3 window base");
        drive(0, 32'hE000_0100, 0, "R7 no valid");
        drive(1, 32'hFFFE_0010, 1, "R5 io rebase");
        drive(1, 32'hFFFE_0010, 0, "R7 io addr as mem");
        drive(1, 32'hE000_0040, 1, "R7 mem addr as io");
        drive(1, 32'hE000_0044, 0, "R6 back-to-back");
        drive(1, 32'hE000_0048, 0, "R6 back-to-back");
        drive(0, 32'h0, 0, "R6 single cycle");

        setcfg(2'b01, 32'hE000_0000, 32'hFFFC_0000, 32'hFFFE_0000, 32'hFFFF_0000,
               32'h0, 32'hFFC0_4000);
        drive(1, 32'hE000_0200, 0, "R1 mem disabled");
        drive(1, 32'hFFFE_0020, 1, "R1 io enabled");
        setcfg(2'b10, 32'hE000_0000, 32'hFFFC_0000, 32'hFFFE_0000, 32'hFFFF_0000,
               32'h0, 32'hFFC0_4000);
        drive(1, 32'hFFFE_0030, 1, "R1 io disabled");
        drive(1, 32'hE000_0300, 0, "R1 mem enabled");

        setcfg(2'b11, 32'hE000_0000, 32'h0, 32'hFFFE_0000, 32'h0, 32'h0, 32'hFFC0_4000);
        drive(1, 32'hE000_0400, 0, "R2 mem mask zero");
        drive(1, 32'hFFFE_0040, 1, "R2 io mask zero");

        setcfg(2'b11, 32'hE000_0000, 32'hF800_0000, 32'hFFFE_0000, 32'hFFFF_0000,
               32'hF000_0000, 32'hFFC0_4000);
        drive(1, 32'hE7FF_FFFC, 0, "R8 mem 128MB last");
        drive(1, 32'hE800_0000, 0, "R8 mem 128MB past");
        drive(1, 32'hE000_1234, 0, "R4 nonzero base");
        drive(1, 32'hFFFE_FFFF, 1, "R8 io 64KB last");
        drive(1, 32'hFFFF_0000, 1, "R8 io 64KB past");
        drive(1, 32'hFFFD_FFFF, 1, "R8 io below");
        drive(0, 32'h0, 0, "R7 idle end");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule